// File: doc/BRIEF.md
# Pairwise-Order Transition Encoder

This block turns a set of pairwise order decisions into a timed sequence of single-wire transitions on a small bundle of output wires. For every unordered pair of wires, one input bit says which of the two must change level first. The block accepts one such set through a valid/ready handshake. It checks that the decisions describe a real ordering. It then toggles every output wire exactly once, one wire per step, in the order the bits require. The information of a symbol lies only in the order of the changes, so a bundle of N wires carries one of N! symbols.

Consecutive transitions are separated by a gap, in clock cycles, that is given with each symbol. When the last wire has changed, a one-cycle completion pulse follows and the block is ready again. A set of decisions that contains a cycle, such as a before b, b before c and c before a, has no valid ordering. The block flags it as an error and leaves the wires untouched.

Top module: `phenc_top`

## Requirements
- R1: While reset is asserted and right after it, all wires are low, `done` and `err` are low and `in_ready` is high.
- R2: A symbol is accepted on a clock edge where `in_valid` and `in_ready` are both high. For an acyclic symbol, `in_ready` stays low from the cycle after acceptance until the completion pulse. Input changes during that time have no effect on the wires.
- R3: Bit p of `order_bits` describes the pair (k, j) with k < j, where p = k*N - k*(k+1)/2 + (j-k-1). A value of 1 means wire k changes before wire j. A value of 0 means wire j changes before wire k.
- R4: Each accepted acyclic symbol toggles every wire exactly once, and never more than one wire per clock edge.
- R5: The wire that has p predecessors under the pairwise bits is the p-th to toggle, counting from 0.
- R6: The first toggle happens on the clock edge after acceptance. Later toggles follow every G cycles, where G is the `gap` value latched at acceptance, and a `gap` of 0 acts as 1.
- R7: `done` is high for exactly one cycle, one cycle after the last toggle. During that cycle `in_ready` is high.
- R8: A cyclic symbol raises `err` from the edge of acceptance. No wire toggles, the block stays ready, and `err` holds until the next accepted symbol.
- R9: The wires keep their levels between symbols. A symbol leaves each wire inverted relative to its level before the symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Symbol offered |
| in_ready | output | 1 | Block idle and able to accept |
| order_bits | input | N*(N-1)/2 | Pairwise order decisions |
| gap | input | GAP_W | Cycles between transitions |
| wires | output | N | Transition-signalled output bundle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last accepted symbol was cyclic |

## Verification
The bench sweeps every pairwise bit pattern of a four-wire bundle under several gaps. This covers all 24 orderings and all 40 cyclic patterns. A design with a swapped pair polarity or a wrong bit index would toggle wires in the wrong order. A design with a weak cycle test would either emit a partial symbol or stall waiting for a wire that can never fire. A gap of zero is included, so a design that fails to clamp it would emit transitions with no spacing or wrap its counter. During each symbol the bench drives a different pattern with valid held high, so a design that accepts input while busy would change the order or restart.

// File: rtl/phenc_pkg.sv
package phenc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } phenc_state_e;

    // Position of the bit for pair (k, j), k < j, enumerated k-major.
    function automatic int pair_idx(input int k, input int j, input int n);
        return k * n - (k * (k + 1)) / 2 + (j - k - 1);
    endfunction
endpackage

// File: rtl/phenc_prec.sv
// Expands the pairwise bits into a predecessor mask for each wire.
module phenc_prec #(
    parameter int N = 4,
    localparam int NP = N * (N - 1) / 2
) (
    input  logic [NP-1:0]       pairs,
    output logic [N-1:0][N-1:0] pred
);
    import phenc_pkg::*;

    for (genvar j = 0; j < N; j++) begin : g_row
        for (genvar k = 0; k < N; k++) begin : g_col
            if (k < j) begin : g_lo
                assign pred[j][k] = pairs[pair_idx(k, j, N)];
            end else if (k > j) begin : g_hi
                assign pred[j][k] = ~pairs[pair_idx(j, k, N)];
            end else begin : g_self
                assign pred[j][k] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/phenc_check.sv
// A complete tournament is acyclic exactly when all in-degrees differ.
module phenc_check #(
    parameter int N = 4,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0][N-1:0] pred,
    output logic                acyclic
);
    logic [N-1:0][CW-1:0] indeg;

    always_comb begin
        for (int j = 0; j < N; j++) begin
            indeg[j] = CW'($countones(pred[j]));
        end
        acyclic = 1'b1;
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                if (indeg[a] == indeg[b]) begin
                    acyclic = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/phenc_pick.sv
// Selects the next wire whose predecessors have all fired.
module phenc_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0][N-1:0] pred,
    input  logic [N-1:0]        fired,
    output logic [N-1:0]        pick
);
    logic [N-1:0] eligible;

    for (genvar j = 0; j < N; j++) begin : g_elig
        assign eligible[j] = ~fired[j] && ((pred[j] & ~fired) == '0);
    end

    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int j = 0; j < N; j++) begin
            if (eligible[j] && !found) begin
                pick[j] = 1'b1;
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/phenc_top.sv
module phenc_top #(
    parameter int N     = 4,
    parameter int GAP_W = 4,
    localparam int NP   = N * (N - 1) / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [NP-1:0]    order_bits,
    input  logic [GAP_W-1:0] gap,
    output logic [N-1:0]     wires,
    output logic             done,
    output logic             err
);
    import phenc_pkg::*;

    typedef struct packed {
        phenc_state_e         state;
        logic [N-1:0][N-1:0]  pred;
        logic [N-1:0]         fired;
        logic [GAP_W-1:0]     cnt;
        logic [GAP_W-1:0]     gap;
        logic [N-1:0]         wires;
        logic                 done;
        logic                 err;
    } regs_t;

    regs_t r_q, r_d;

    logic [N-1:0][N-1:0] in_pred;
    logic                in_acyclic;
    logic [N-1:0]        next_pick;

    phenc_prec #(.N(N)) u_prec (
        .pairs (order_bits),
        .pred  (in_pred)
    );

    phenc_check #(.N(N)) u_check (
        .pred    (in_pred),
        .acyclic (in_acyclic)
    );

    phenc_pick #(.N(N)) u_pick (
        .pred  (r_q.pred),
        .fired (r_q.fired),
        .pick  (next_pick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.err = ~in_acyclic;
                    if (in_acyclic) begin
                        r_d.state = ST_RUN;
                        r_d.pred  = in_pred;
                        r_d.fired = '0;
                        r_d.cnt   = '0;
                        r_d.gap   = (gap == '0) ? GAP_W'(1) : gap;
                    end
                end
            end
            ST_RUN: begin
                if (&r_q.fired) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (r_q.cnt == '0) begin
                    r_d.wires = r_q.wires ^ next_pick;
                    r_d.fired = r_q.fired | next_pick;
                    r_d.cnt   = r_q.gap - GAP_W'(1);
                end else begin
                    r_d.cnt = r_q.cnt - GAP_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready = (r_q.state == ST_IDLE);
    assign wires    = r_q.wires;
    assign done     = r_q.done;
    assign err      = r_q.err;
endmodule

// File: rtl/phenc_chk.sv
module phenc_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_ready,
    input logic [N-1:0] wires,
    input logic         done,
    input logic         err
);
    p_one_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wires ^ $past(wires)) <= 1);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> $stable(wires));

    p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> in_ready);
endmodule

bind phenc_top phenc_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .wires    (wires),
    .done     (done),
    .err      (err)
);

// File: tb/phenc_top_test.sv
module phenc_top_test;
    localparam int N  = 4;
    localparam int GW = 4;
    localparam int NP = N * (N - 1) / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [NP-1:0] order_bits;
    logic [GW-1:0] gap;
    logic [N-1:0]  wires;
    logic          done;
    logic          err;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    phenc_top #(.N(N), .GAP_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .order_bits(order_bits), .gap(gap), .wires(wires), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int idx(input int k, input int j);
        return k * N - (k * (k + 1)) / 2 + (j - k - 1);
    endfunction

    task automatic run_one(input int v, input int g);
        int          npred[N];
        bit          acyc;
        int          step;
        int          last_i;
        logic [N-1:0] base;
        logic [N-1:0] expm;
        // predecessor counts from the R3 bit layout
        for (int j = 0; j < N; j++) begin
            npred[j] = 0;
            for (int k = 0; k < N; k++) begin
                if (k < j && v[idx(k, j)]) npred[j]++;
                if (k > j && !v[idx(j, k)]) npred[j]++;
            end
        end
        acyc = 1'b1;
        for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++)
                if (npred[a] == npred[b]) acyc = 1'b0;
        step = (g == 0) ? 1 : g;

        @(negedge clk);
        base = wires;
        chk(in_ready == 1'b1, "R2", "ready before offer", int'(in_ready), 1);
        in_valid   = 1'b1;
        order_bits = NP'(v);
        gap        = GW'(g);
        @(negedge clk); // i = 0, just after the accepting edge
        if (!acyc) begin
            chk(err == 1'b1, "R8", "err on cyclic", int'(err), 1);
            chk(in_ready == 1'b1, "R8", "ready after cyclic", int'(in_ready), 1);
            in_valid = 1'b0;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(wires == base, "R8", "no toggles on cyclic", int'(wires), int'(base));
                chk(err == 1'b1 && done == 1'b0, "R8", "err held, no done",
                    int'({err, done}), 2);
            end
            return;
        end
        chk(err == 1'b0, "R8", "err clear on acyclic", int'(err), 0);
        chk(in_ready == 1'b0, "R2", "busy after accept", int'(in_ready), 0);
        chk(wires == base, "R6", "no toggle at accept", int'(wires), int'(base));
        order_bits = ~NP'(v); // offered while busy: must be ignored
        last_i = 1 + (N - 1) * step + 1;
        for (int i = 1; i <= last_i; i++) begin
            @(negedge clk);
            expm = '0;
            for (int w = 0; w < N; w++)
                if (1 + npred[w] * step <= i) expm[w] = 1'b1;
            chk(wires == (base ^ expm), "R5", "wire order/timing (R6)",
                int'(wires), int'(base ^ expm));
            chk(done == (i == last_i), "R7", "done timing", int'(done), int'(i == last_i));
            if (i < last_i)
                chk(in_ready == 1'b0, "R2", "ready low while busy", int'(in_ready), 0);
            else begin
                chk(in_ready == 1'b1, "R7", "ready with done", int'(in_ready), 1);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R7", "done single cycle", int'(done), 0);
        chk(wires == ~base, "R4", "each wire toggled once (R9)", int'(wires), int'(~base));
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        order_bits = '0;
        gap        = GW'(1);
        repeat (3) @(negedge clk);
        chk(wires == '0 && done == 1'b0 && err == 1'b0, "R1", "reset outputs",
            int'({wires, done, err}), 0);
        chk(in_ready == 1'b1, "R1", "reset ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wires == '0 && in_ready == 1'b1, "R1", "after reset",
            int'({wires, in_ready}), 1);
        for (int gi = 0; gi < 3; gi++) begin
            for (int v = 0; v < (1 << NP); v++) begin
                run_one(v, (gi == 0) ? 0 : (gi == 1) ? 1 : 3);
            end
        end
        // level retained while idle (R9)
        begin
            logic [N-1:0] hold;
            hold = wires;
            repeat (4) @(negedge clk);
            chk(wires == hold, "R9", "levels kept idle", int'(wires), int'(hold));
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule